// File: doc/BRIEF.md
# UART Register-Bus Bridge

This block lets a host computer reach on-chip control and status registers over a two-wire serial link. It contains a UART receiver and a UART transmitter running at a fixed baud rate, plus a request parser. The parser decodes framed requests and turns each one into a burst of accesses on an 8-bit register bus.

A request starts with a command byte and a burst length. A 32-bit start address follows, sent most significant byte first. For a write request, one data byte per burst item comes after the address, and each byte goes out as a single-cycle bus write. For a read request, the bridge performs one bus read per item and returns every result byte over the transmit line in address order. Each item uses the start address plus its index in the burst.

The bus is single-cycle. A strobe, the address and the write data are valid for one clock. Read data is taken on the clock after the read address is presented.

Top module: `uart_reg_bridge`

## Requirements
- R1: Serial frames are 8N1. A low start bit is followed by eight data bits, least significant bit first, then a high stop bit. Every bit lasts CLK_HZ/BAUD clocks, and the transmit line rests high between frames.
- R2: While idle, a received byte of 0x01 opens a write request and 0x02 opens a read request. Any other byte is ignored: the parser stays idle and no bus access follows.
- R3: The byte after the command is the burst length, counted in data bytes. A length of 0 causes no bus access and returns the parser to idle straight after the address.
- R4: The four bytes after the length form the start address, most significant byte first.
- R5: In a write request, each following data byte produces one bus_we pulse lasting a single clock. bus_addr and bus_wdata are valid in that clock, and bus_addr holds its value from the clock before.
- R6: Burst item k uses address start + k. The full 32 bits are incremented, so the count carries across byte boundaries.
- R7: In a read request, each item produces one bus_re pulse lasting a single clock. bus_rdata is taken on the following clock and sent as one serial frame, with the frames leaving in address order.
- R8: bus_we and bus_re are never high in the same clock.
- R9: After reset, tx_o is high and both bus strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_i | input | 1 | Serial data from host (asynchronous) |
| tx_o | output | 1 | Serial data to host |
| bus_we | output | 1 | Single-cycle register write strobe |
| bus_re | output | 1 | Single-cycle register read strobe |
| bus_addr | output | 32 | Register address |
| bus_wdata | output | 8 | Register write data |
| bus_rdata | input | 8 | Register read data, valid the clock after bus_re |

## Verification
The bench sends multi-byte write bursts with a nonzero upper address. This shows that every address byte lands in the correct position and that the address increments per item. Read bursts of the same range then check that the returned frames come back in address order with the stored values. A burst that starts at 0x000000FF checks that the increment carries into the next byte. Two further patterns each end with a valid request whose result is checked. In the first, stray command bytes come before the request; in the second, a zero-length write does. Both show that the parser returned to idle without touching the bus.

// File: rtl/urb_pkg.sv
package urb_pkg;
   localparam logic [7:0] OP_WRITE = 8'h01;
   localparam logic [7:0] OP_READ  = 8'h02;
   localparam int         ADDR_W   = 32;
   localparam int         DATA_W   = 8;

   typedef enum logic [2:0] {
      PS_IDLE, PS_LEN, PS_ADDR, PS_WR_WAIT, PS_WR_PUT,
      PS_RD_REQ, PS_RD_TAKE, PS_RD_SEND
   } parse_st_e;
endpackage

// File: rtl/urb_rx.sv
module urb_rx #(
   parameter int DIV         = 434,
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       line_i,
   output logic       byte_vld,
   output logic [7:0] byte_dat
);
   localparam int CW   = $clog2(DIV + 1);
   localparam int HALF = DIV / 2;

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   rxs;

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
         if (s == 0) begin : g_first
            always_ff @(posedge clk) sync_q[0] <= rst_n ? line_i : 1'b1;
         end else begin : g_next
            always_ff @(posedge clk) sync_q[s] <= rst_n ? sync_q[s-1] : 1'b1;
         end
      end
   endgenerate
   assign rxs = sync_q[SYNC_STAGES-1];

   typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_st_e;
   rx_st_e        st;
   logic [CW-1:0] cnt;
   logic [2:0]    nbit;
   logic [7:0]    shf;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st       <= RX_IDLE;
         cnt      <= '0;
         nbit     <= '0;
         shf      <= '0;
         byte_vld <= 1'b0;
      end else begin
         byte_vld <= 1'b0;
         case (st)
            RX_IDLE: if (!rxs) begin
               cnt <= CW'(HALF - 1);
               st  <= RX_START;
            end
            RX_START: if (cnt == 0) begin
               if (!rxs) begin
                  cnt  <= CW'(DIV - 1);
                  nbit <= '0;
                  st   <= RX_DATA;
               end else st <= RX_IDLE;
            end else cnt <= cnt - 1'b1;
            RX_DATA: if (cnt == 0) begin
               shf <= {rxs, shf[7:1]};
               cnt <= CW'(DIV - 1);
               if (nbit == 3'd7) st <= RX_STOP;
               else nbit <= nbit + 1'b1;
            end else cnt <= cnt - 1'b1;
            RX_STOP: if (cnt == 0) begin
               byte_vld <= 1'b1;
               st       <= RX_IDLE;
            end else cnt <= cnt - 1'b1;
            default: st <= RX_IDLE;
         endcase
      end
   end
   assign byte_dat = shf;
endmodule

// File: rtl/urb_tx.sv
module urb_tx #(
   parameter int DIV = 434
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start,
   input  logic [7:0] dat,
   output logic       busy,
   output logic       line_o
);
   localparam int CW = $clog2(DIV + 1);

   logic [9:0]    shf;
   logic [3:0]    nbit;
   logic [CW-1:0] cnt;
   logic          act;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         act  <= 1'b0;
         shf  <= '1;
         nbit <= '0;
         cnt  <= '0;
      end else if (!act) begin
         if (start) begin
            shf  <= {1'b1, dat, 1'b0};
            nbit <= '0;
            cnt  <= CW'(DIV - 1);
            act  <= 1'b1;
         end
      end else if (cnt == 0) begin
         shf <= {1'b1, shf[9:1]};
         cnt <= CW'(DIV - 1);
         if (nbit == 4'd9) act <= 1'b0;
         else nbit <= nbit + 1'b1;
      end else cnt <= cnt - 1'b1;
   end

   assign busy   = act;
   assign line_o = act ? shf[0] : 1'b1;
endmodule

// File: rtl/urb_parser.sv
module urb_parser
   import urb_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_vld,
   input  logic [7:0]        rx_dat,
   input  logic              tx_busy,
   output logic              tx_start,
   output logic [7:0]        tx_dat,
   output logic              bus_we,
   output logic              bus_re,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [DATA_W-1:0] bus_wdata,
   input  logic [DATA_W-1:0] bus_rdata
);
   localparam int NAB = ADDR_W / 8;

   parse_st_e         st;
   logic              is_wr;
   logic [7:0]        len;
   logic [7:0]        idx;
   logic [1:0]        acnt;
   logic [ADDR_W-1:0] base;
   logic [7:0]        hold;
   logic              last;

   assign last = (idx == len - 8'd1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st    <= PS_IDLE;
         is_wr <= 1'b0;
         len   <= '0;
         idx   <= '0;
         acnt  <= '0;
         base  <= '0;
         hold  <= '0;
      end else begin
         case (st)
            PS_IDLE: if (rx_vld && (rx_dat == OP_WRITE || rx_dat == OP_READ)) begin
               is_wr <= (rx_dat == OP_WRITE);
               st    <= PS_LEN;
            end
            PS_LEN: if (rx_vld) begin
               len  <= rx_dat;
               acnt <= '0;
               st   <= PS_ADDR;
            end
            PS_ADDR: if (rx_vld) begin
               base <= {base[ADDR_W-9:0], rx_dat};
               acnt <= acnt + 1'b1;
               idx  <= '0;
               if (acnt == 2'(NAB - 1)) begin
                  if (len == 0)   st <= PS_IDLE;
                  else if (is_wr) st <= PS_WR_WAIT;
                  else            st <= PS_RD_REQ;
               end
            end
            PS_WR_WAIT: if (rx_vld) begin
               hold <= rx_dat;
               st   <= PS_WR_PUT;
            end
            PS_WR_PUT: begin
               idx <= idx + 1'b1;
               st  <= last ? PS_IDLE : PS_WR_WAIT;
            end
            PS_RD_REQ:  st <= PS_RD_TAKE;
            PS_RD_TAKE: begin
               hold <= bus_rdata;
               st   <= PS_RD_SEND;
            end
            PS_RD_SEND: if (!tx_busy) begin
               idx <= idx + 1'b1;
               st  <= last ? PS_IDLE : PS_RD_REQ;
            end
            default: st <= PS_IDLE;
         endcase
      end
   end

   assign bus_addr  = base + ADDR_W'(idx);
   assign bus_we    = (st == PS_WR_PUT);
   assign bus_re    = (st == PS_RD_REQ);
   assign bus_wdata = hold;
   assign tx_dat    = hold;
   assign tx_start  = (st == PS_RD_SEND) && !tx_busy;
endmodule

// File: rtl/uart_reg_bridge.sv
module uart_reg_bridge #(
   parameter int CLK_HZ      = 50_000_000,
   parameter int BAUD        = 115_200,
   parameter int SYNC_STAGES = 2
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        rx_i,
   output logic        tx_o,
   output logic        bus_we,
   output logic        bus_re,
   output logic [31:0] bus_addr,
   output logic [7:0]  bus_wdata,
   input  logic [7:0]  bus_rdata
);
   localparam int DIV = CLK_HZ / BAUD;

   generate
      if (DIV < 4) begin : g_bad_div
         $error("CLK_HZ/BAUD must be at least 4");
      end
   endgenerate

   logic       rx_vld, tx_busy, tx_start;
   logic [7:0] rx_dat, tx_dat;

   urb_rx #(.DIV(DIV), .SYNC_STAGES(SYNC_STAGES)) u_rx (
      .clk(clk), .rst_n(rst_n), .line_i(rx_i),
      .byte_vld(rx_vld), .byte_dat(rx_dat));

   urb_tx #(.DIV(DIV)) u_tx (
      .clk(clk), .rst_n(rst_n), .start(tx_start), .dat(tx_dat),
      .busy(tx_busy), .line_o(tx_o));

   urb_parser u_par (
      .clk(clk), .rst_n(rst_n), .rx_vld(rx_vld), .rx_dat(rx_dat),
      .tx_busy(tx_busy), .tx_start(tx_start), .tx_dat(tx_dat),
      .bus_we(bus_we), .bus_re(bus_re), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata));
endmodule

// File: rtl/uart_reg_bridge_chk.sv
module uart_reg_bridge_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        bus_we,
   input logic        bus_re,
   input logic [31:0] bus_addr
);
   a_r8_strobe_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_we && bus_re));
   a_r5_we_single: assert property (@(posedge clk) disable iff (!rst_n)
      bus_we |=> !bus_we);
   a_r7_re_single: assert property (@(posedge clk) disable iff (!rst_n)
      bus_re |=> !bus_re);
   a_r5_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
      bus_we |-> $stable(bus_addr));
endmodule

bind uart_reg_bridge uart_reg_bridge_chk u_chk (
   .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_re(bus_re), .bus_addr(bus_addr));

// File: tb/sim_uart_reg_bridge.sv
module sim_uart_reg_bridge;
   localparam int CLK_HZ = 4_000_000;
   localparam int BAUD   = 250_000;
   localparam int DIV    = CLK_HZ / BAUD;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rx_i = 1'b1;
   logic        tx_o, bus_we, bus_re;
   logic [31:0] bus_addr;
   logic [7:0]  bus_wdata;
   logic [7:0]  bus_rdata = 8'h00;
   logic [7:0]  mem [256];

   int n_chk = 0;
   int n_err = 0;
   bit finished = 0;

   logic [39:0] exp_wr [$];
   logic [7:0]  exp_tx [$];

   always #2 clk = ~clk;

   uart_reg_bridge #(.CLK_HZ(CLK_HZ), .BAUD(BAUD)) u0 (
      .clk(clk), .rst_n(rst_n), .rx_i(rx_i), .tx_o(tx_o),
      .bus_we(bus_we), .bus_re(bus_re), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata));

   initial for (int i = 0; i < 256; i++) mem[i] = 8'h00;

   always @(posedge clk) begin
      if (bus_re) bus_rdata <= mem[bus_addr[7:0]];
      if (bus_we) mem[bus_addr[7:0]] <= bus_wdata;
   end

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic send_byte(input logic [7:0] b);
      rx_i = 1'b0;
      repeat (DIV) @(negedge clk);
      for (int k = 0; k < 8; k++) begin
         rx_i = b[k];
         repeat (DIV) @(negedge clk);
      end
      rx_i = 1'b1;
      repeat (DIV * 2) @(negedge clk);
   endtask

   task automatic send_hdr(input logic [7:0] op, input logic [7:0] n, input logic [31:0] a);
      send_byte(op);
      send_byte(n);
      send_byte(a[31:24]);
      send_byte(a[23:16]);
      send_byte(a[15:8]);
      send_byte(a[7:0]);
   endtask

   // R5 R6: expected write items go to the scoreboard before sending
   task automatic do_write(input logic [31:0] a, input logic [7:0] d [$]);
      for (int i = 0; i < d.size(); i++) exp_wr.push_back({a + 32'(i), d[i]});
      send_hdr(8'h01, 8'(d.size()), a);
      for (int i = 0; i < d.size(); i++) send_byte(d[i]);
      repeat (DIV * 4) @(negedge clk);
   endtask

   // R7: expected returned bytes, in address order
   task automatic do_read(input logic [31:0] a, input logic [7:0] d [$]);
      for (int i = 0; i < d.size(); i++) exp_tx.push_back(d[i]);
      send_hdr(8'h02, 8'(d.size()), a);
      repeat (DIV * (12 * d.size() + 6)) @(negedge clk);
   endtask

   // write monitor, R5 R6 R2 R3 (unexpected writes flagged)
   always @(negedge clk) begin
      if (rst_n && bus_we) begin
         if (exp_wr.size() == 0) chk(0, "R2/R3 unexpected write", {bus_addr, bus_wdata}, 0);
         else begin
            logic [39:0] e;
            e = exp_wr.pop_front();
            chk({bus_addr, bus_wdata} == e, "R5/R6 write addr+data", {bus_addr, bus_wdata}, e);
         end
      end
   end

   // serial transmit monitor, R1 R7
   initial begin
      logic [7:0] b;
      forever begin
         @(negedge clk);
         if (rst_n && tx_o == 1'b0) begin
            repeat (DIV / 2) @(negedge clk);
            chk(tx_o == 1'b0, "R1 start bit", tx_o, 0);
            for (int k = 0; k < 8; k++) begin
               repeat (DIV) @(negedge clk);
               b[k] = tx_o;
            end
            repeat (DIV) @(negedge clk);
            chk(tx_o == 1'b1, "R1 stop bit", tx_o, 1);
            if (exp_tx.size() == 0) chk(0, "R7 unexpected tx byte", b, 0);
            else begin
               logic [7:0] e;
               e = exp_tx.pop_front();
               chk(b == e, "R7 read byte", b, e);
            end
         end
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_err++;
         $display("FAIL watchdog expired");
         $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   end

   initial begin
      repeat (5) @(negedge clk);
      chk(tx_o == 1'b1, "R9 tx idle after reset", tx_o, 1);
      chk(!bus_we && !bus_re, "R9 strobes low", {bus_we, bus_re}, 0);
      rst_n = 1'b1;
      repeat (10) @(negedge clk);
      chk(tx_o == 1'b1, "R1 tx rests high", tx_o, 1);

      // R4 R5 R6: burst with a nonzero upper address
      do_write(32'h12345610, '{8'hA5, 8'h5A, 8'h3C});
      // R7: read back in order
      do_read(32'h12345610, '{8'hA5, 8'h5A, 8'h3C});
      // R2: stray bytes 0x07 and 0x03 ignored, then a valid write
      send_byte(8'h07);
      send_byte(8'h03);
      do_write(32'hCAFE0001, '{8'h77});
      // R3: zero-length write, then a read must decode normally
      send_hdr(8'h01, 8'h00, 32'h00000020);
      do_read(32'h12345611, '{8'h5A});
      // R6: carry across a byte boundary
      do_write(32'h000000FF, '{8'h11, 8'h22});
      do_read(32'h000000FF, '{8'h11, 8'h22});

      repeat (DIV * 20) @(negedge clk);
      chk(exp_wr.size() == 0, "R5 all writes seen", exp_wr.size(), 0);
      chk(exp_tx.size() == 0, "R7 all read bytes seen", exp_tx.size(), 0);
      finished = 1;
      $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end
endmodule